// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Set Keys and Hourly Chime

This block keeps a 24-hour time of day as six BCD digits: tens and units of hours, of minutes and of seconds. It runs on one clock, `clk`, at twice the 1 kHz reference rate. An internal prescaler makes a 1 kHz sample enable from it, then a 10 Hz fast tick, then a 1 Hz tick that advances the seconds. Every counter uses these enables. None of them is a derived clock.

Three active-high push buttons set the time. The hour key and the minute key each add one count per fast tick while they are held. A minute wrap caused by the minute key never carries into the hours. The seconds key holds both seconds digits at zero. Each key first passes through a two-flop synchronizer. It then passes through a filter that accepts a new level only after that level has been seen on a run of consecutive 1 kHz samples, so contact bounce cannot add an extra step.

A single speaker pin plays the hourly chime. A 500 Hz square wave sounds on the even seconds of 50 to 58 in minute 59. A 1 kHz square wave sounds for the whole of second 00 of minute 00. At every other time the pin is low. The display scan and the segment decoding live outside this block.

Top module: `bcd_clock_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the time to 00:00:00.
- R2: Seconds advance by one on each 1 Hz tick. The tick comes every CLK_PER_REF × REF_PER_FAST × FAST_PER_SEC clock cycles. The units digit runs 0 to 9 and then bumps the tens digit. 59 is followed by 00.
- R3: A seconds roll from 59 to 00 advances the minutes by one. A minutes roll from 59 to 00 caused by that carry advances the hours by one.
- R4: While the hour key is accepted as pressed, the hours step by one per fast tick (every CLK_PER_REF × REF_PER_FAST cycles) through 00..23. After 23 comes 00.
- R5: While the minute key is accepted as pressed, the minutes step by one per fast tick through 00..59. A roll from 59 to 00 made by this key leaves the hours unchanged.
- R6: While the seconds key is accepted as pressed, both seconds digits read 0. The minutes receive no carry from the seconds.
- R7: A key level is accepted only after DEB_SAMPLES consecutive 1 kHz samples (default 20) have agreed on it. A key that toggles faster than that causes no step.
- R8: When a seconds carry and a minute-key step fall on the same tick, the minutes advance by exactly one.
- R9: With minutes at 59, seconds tens at 5 and seconds units even, the speaker carries a square wave with a period of 2 × CLK_PER_REF cycles (500 Hz).
- R10: With minutes and seconds all zero, which includes the first second after reset, the speaker carries a square wave with a period of CLK_PER_REF cycles (1 kHz).
- R11: At all other times the speaker is 0. The speaker output lags the time digits by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_PER_REF times the 1 kHz reference |
| rst | input | 1 | Synchronous reset, active high |
| key_hour | input | 1 | Raw hour-advance button, active high |
| key_min | input | 1 | Raw minute-advance button, active high |
| key_sec | input | 1 | Raw seconds-clear button, active high |
| hr_tens | output | 4 | Hours tens digit, BCD |
| hr_units | output | 4 | Hours units digit, BCD |
| mn_tens | output | 4 | Minutes tens digit, BCD |
| mn_units | output | 4 | Minutes units digit, BCD |
| sc_tens | output | 4 | Seconds tens digit, BCD |
| sc_units | output | 4 | Seconds units digit, BCD |
| speaker | output | 1 | Chime square wave, 0 when silent |

## Verification
The main function is tried with free running, with each key held clean, and with a key chattering faster than the filter window.

- Free running shows whether the seconds step once per tick and whether the carries into minutes and hours happen.
- Holding each key cleanly shows the step rate and the two wraps, including that a key-made minute wrap does not touch the hours.
- The chattering key separates a working filter from one that passes bounce through.

The chime is measured by counting speaker edges across the middle of chosen seconds. This tells 500 Hz, 1 kHz and silence apart. Holding the minute key across a seconds roll shows whether a coincident carry and key step are merged into one count.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;
  typedef logic [3:0] bcd_t;

  typedef struct packed {
    bcd_t tens;
    bcd_t units;
  } bcd_pair_t;

  localparam bcd_t BCD_NINE = 4'd9;
endpackage

// File: rtl/clk_tick_gen.sv
module clk_tick_gen #(
  parameter int CLK_PER_REF  = 2,
  parameter int REF_PER_FAST = 100,
  parameter int FAST_PER_SEC = 10
) (
  input  logic clk,
  input  logic rst,
  output logic ref_tick,
  output logic fast_tick,
  output logic sec_tick,
  output logic tone_lo,
  output logic tone_hi
);
  localparam int DW   = (CLK_PER_REF  > 2) ? $clog2(CLK_PER_REF)  : 1;
  localparam int RW   = (REF_PER_FAST > 2) ? $clog2(REF_PER_FAST) : 1;
  localparam int SW   = (FAST_PER_SEC > 2) ? $clog2(FAST_PER_SEC) : 1;
  localparam int HALF = CLK_PER_REF / 2;

  logic [DW-1:0] div_q;
  logic [RW-1:0] ref_q;
  logic [SW-1:0] fast_q;

  assign ref_tick  = (div_q == DW'(CLK_PER_REF - 1));
  assign fast_tick = ref_tick && (ref_q == RW'(REF_PER_FAST - 1));
  assign sec_tick  = fast_tick && (fast_q == SW'(FAST_PER_SEC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      ref_q   <= '0;
      fast_q  <= '0;
      tone_lo <= 1'b0;
      tone_hi <= 1'b0;
    end else begin
      div_q <= ref_tick ? '0 : div_q + 1'b1;
      if (div_q == '0 || div_q == DW'(HALF))
        tone_hi <= ~tone_hi;
      if (ref_tick) begin
        tone_lo <= ~tone_lo;
        ref_q   <= fast_tick ? '0 : ref_q + 1'b1;
      end
      if (fast_tick)
        fast_q <= sec_tick ? '0 : fast_q + 1'b1;
    end
  end
endmodule

// File: rtl/key_filter.sv
module key_filter #(
  parameter int DEB_SAMPLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(DEB_SAMPLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      run_q  <= '0;
      level  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sample_en) begin
        if (sync_q[1] != level) begin
          if (run_q == CW'(DEB_SAMPLES - 1)) begin
            level <= sync_q[1];
            run_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          run_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_pair_counter.sv
module bcd_pair_counter
  import bcd_clk_pkg::*;
#(
  parameter int TOP_TENS  = 5,
  parameter int TOP_UNITS = 9
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clear,
  input  logic      step,
  output bcd_pair_t value,
  output logic      at_top
);
  assign at_top = (value.tens == 4'(TOP_TENS)) && (value.units == 4'(TOP_UNITS));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      value <= '0;
    end else if (step) begin
      if (at_top) begin
        value <= '0;
      end else if (value.units == BCD_NINE) begin
        value.units <= '0;
        value.tens  <= value.tens + 1'b1;
      end else begin
        value.units <= value.units + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chime_gate.sv
module chime_gate
  import bcd_clk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  bcd_pair_t minutes,
  input  bcd_pair_t seconds,
  input  logic      tone_lo,
  input  logic      tone_hi,
  output logic      speaker
);
  logic warn_win;
  logic hour_win;

  assign warn_win = (minutes.tens == 4'd5) && (minutes.units == 4'd9) &&
                    (seconds.tens == 4'd5) && !seconds.units[0];
  assign hour_win = (minutes == '0) && (seconds == '0);

  always_ff @(posedge clk) begin
    if (rst) speaker <= 1'b0;
    else     speaker <= (warn_win && tone_lo) || (hour_win && tone_hi);
  end
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clk_pkg::*;
#(
  parameter int CLK_PER_REF  = 2,
  parameter int REF_PER_FAST = 100,
  parameter int FAST_PER_SEC = 10,
  parameter int DEB_SAMPLES  = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_hour,
  input  logic       key_min,
  input  logic       key_sec,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_units,
  output logic [3:0] mn_tens,
  output logic [3:0] mn_units,
  output logic [3:0] sc_tens,
  output logic [3:0] sc_units,
  output logic       speaker
);
  localparam int NKEYS = 3;

  logic ref_tick, fast_tick, sec_tick, tone_lo, tone_hi;

  clk_tick_gen #(
    .CLK_PER_REF (CLK_PER_REF),
    .REF_PER_FAST(REF_PER_FAST),
    .FAST_PER_SEC(FAST_PER_SEC)
  ) u_ticks (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .fast_tick(fast_tick),
    .sec_tick (sec_tick),
    .tone_lo  (tone_lo),
    .tone_hi  (tone_hi)
  );

  logic [NKEYS-1:0] raw_keys;
  logic [NKEYS-1:0] key_lvl;
  assign raw_keys = {key_sec, key_min, key_hour};

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    key_filter #(.DEB_SAMPLES(DEB_SAMPLES)) u_filt (
      .clk      (clk),
      .rst      (rst),
      .sample_en(ref_tick),
      .raw      (raw_keys[k]),
      .level    (key_lvl[k])
    );
  end

  logic key_hour_lvl, key_min_lvl, key_sec_lvl;
  assign key_hour_lvl = key_lvl[0];
  assign key_min_lvl  = key_lvl[1];
  assign key_sec_lvl  = key_lvl[2];

  bcd_pair_t sec_v, min_v, hr_v;
  logic      sec_top, min_top, hr_top;
  logic      sec_carry, min_step, min_carry, hr_step;

  assign sec_carry = sec_tick && sec_top && !key_sec_lvl;
  assign min_step  = sec_carry || (fast_tick && key_min_lvl);
  assign min_carry = sec_carry && min_top;
  assign hr_step   = min_carry || (fast_tick && key_hour_lvl);

  bcd_pair_counter #(.TOP_TENS(5), .TOP_UNITS(9)) u_sec (
    .clk(clk), .rst(rst), .clear(key_sec_lvl), .step(sec_tick),
    .value(sec_v), .at_top(sec_top)
  );

  bcd_pair_counter #(.TOP_TENS(5), .TOP_UNITS(9)) u_min (
    .clk(clk), .rst(rst), .clear(1'b0), .step(min_step),
    .value(min_v), .at_top(min_top)
  );

  bcd_pair_counter #(.TOP_TENS(2), .TOP_UNITS(3)) u_hr (
    .clk(clk), .rst(rst), .clear(1'b0), .step(hr_step),
    .value(hr_v), .at_top(hr_top)
  );

  chime_gate u_chime (
    .clk    (clk),
    .rst    (rst),
    .minutes(min_v),
    .seconds(sec_v),
    .tone_lo(tone_lo),
    .tone_hi(tone_hi),
    .speaker(speaker)
  );

  assign hr_tens  = hr_v.tens;
  assign hr_units = hr_v.units;
  assign mn_tens  = min_v.tens;
  assign mn_units = min_v.units;
  assign sc_tens  = sec_v.tens;
  assign sc_units = sec_v.units;
endmodule

// File: rtl/bcd_clock_core_checks.sv
module bcd_clock_core_checks (
  input logic       clk,
  input logic       rst,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_units,
  input logic [3:0] mn_tens,
  input logic [3:0] mn_units,
  input logic [3:0] sc_tens,
  input logic [3:0] sc_units,
  input logic       speaker,
  input logic       key_sec_lvl,
  input logic       key_hour_lvl
);
  logic [6:0] hr_n, mn_n, sc_n;
  logic       any_win;

  assign hr_n    = 7'(hr_tens * 10 + hr_units);
  assign mn_n    = 7'(mn_tens * 10 + mn_units);
  assign sc_n    = 7'(sc_tens * 10 + sc_units);
  assign any_win = (mn_n == 7'd59 && sc_tens == 4'd5 && !sc_units[0]) ||
                   (mn_n == 7'd0 && sc_n == 7'd0);

  assert_digits_legal_R2: assert property (@(posedge clk) disable iff (rst)
    sc_units <= 4'd9 && sc_tens <= 4'd5 && mn_units <= 4'd9 && mn_tens <= 4'd5 &&
    hr_units <= 4'd9 && hr_n <= 7'd23);

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (rst)
    (sc_n != $past(sc_n)) |-> (sc_n == $past(sc_n) + 7'd1 || sc_n == 7'd0));

  assert_sec_held_R6: assert property (@(posedge clk) disable iff (rst)
    key_sec_lvl |=> (sc_n == 7'd0));

  assert_min_single_step_R8: assert property (@(posedge clk) disable iff (rst)
    (mn_n != $past(mn_n)) |-> (mn_n == $past(mn_n) + 7'd1 ||
                               ($past(mn_n) == 7'd59 && mn_n == 7'd0)));

  assert_min_wrap_no_carry_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(mn_n) == 7'd59 && mn_n == 7'd0 && $past(sc_n) != 7'd59 && !$past(key_hour_lvl))
      |-> (hr_n == $past(hr_n)));

  assert_hour_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(hr_n) == 7'd23 && hr_n != 7'd23) |-> (hr_n == 7'd0));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !any_win |=> !speaker);
endmodule

bind bcd_clock_core bcd_clock_core_checks u_checks (
  .clk         (clk),
  .rst         (rst),
  .hr_tens     (hr_tens),
  .hr_units    (hr_units),
  .mn_tens     (mn_tens),
  .mn_units    (mn_units),
  .sc_tens     (sc_tens),
  .sc_units    (sc_units),
  .speaker     (speaker),
  .key_sec_lvl (key_sec_lvl),
  .key_hour_lvl(key_hour_lvl)
);

// File: tb/bcd_clock_core_test.sv
`timescale 1ns/1ps
module bcd_clock_core_test;
  localparam int FAST_CYC = 20;   // CLK_PER_REF(2) * REF_PER_FAST(10)
  localparam int SEC_CYC  = 200;  // FAST_CYC * 10

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_hour = 1'b0, key_min = 1'b0, key_sec = 1'b0;
  logic [3:0] hr_tens, hr_units, mn_tens, mn_units, sc_tens, sc_units;
  logic speaker;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  bcd_clock_core #(.CLK_PER_REF(2), .REF_PER_FAST(10), .FAST_PER_SEC(10), .DEB_SAMPLES(20)) uut (
    .clk(clk), .rst(rst), .key_hour(key_hour), .key_min(key_min), .key_sec(key_sec),
    .hr_tens(hr_tens), .hr_units(hr_units), .mn_tens(mn_tens), .mn_units(mn_units),
    .sc_tens(sc_tens), .sc_units(sc_units), .speaker(speaker)
  );

  function automatic int hv(); return hr_tens * 10 + hr_units; endfunction
  function automatic int mv(); return mn_tens * 10 + mn_units; endfunction
  function automatic int sv(); return sc_tens * 10 + sc_units; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_edges(input int n, output int c);
    logic prev;
    c = 0;
    prev = speaker;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (speaker != prev) c++;
      prev = speaker;
    end
  endtask

  task automatic wait_sec(input int target, input int limit);
    for (int i = 0; i < limit && sv() != target; i++) @(negedge clk);
  endtask

  // R1, R10: reset state and hour-top chime
  task automatic t_reset();
    int c;
    step(4);
    rst = 1'b0;
    step(2);
    chk(hv() == 0 && mv() == 0 && sv() == 0, "R1 time after reset", hv()*10000 + mv()*100 + sv(), 0);
    count_edges(20, c);
    chk(c >= 18, "R10 1 kHz chime at 00:00 after reset", c, 20);
  endtask

  // R2, R11: free-running seconds
  task automatic t_seconds();
    int c;
    step(1100 - 22);
    chk(sc_tens == 0 && sc_units == 5, "R2 seconds after five ticks", sv(), 5);
    count_edges(50, c);
    chk(c == 0 && speaker == 1'b0, "R11 silent at 00:05", c, 0);
    step(1000 - 50);
    chk(sc_tens == 1 && sc_units == 0, "R2 units roll into tens", sv(), 10);
  endtask

  // R6: seconds held at zero by key
  task automatic t_sec_clear();
    int m0;
    m0 = mv();
    key_sec = 1'b1;
    step(400);
    chk(sv() == 0, "R6 seconds held at zero", sv(), 0);
    chk(mv() == m0, "R6 minutes untouched", mv(), m0);
    key_sec = 1'b0;
    step(100 + 3 * SEC_CYC);
    chk(sv() >= 2 && sv() <= 4, "R6 seconds resume after release", sv(), 3);
  endtask

  // R7: bouncing key rejected
  task automatic t_bounce();
    int m0, h0;
    m0 = mv();
    h0 = hv();
    for (int i = 0; i < 50; i++) begin
      key_min = ~key_min;
      step(8);
    end
    key_min = 1'b0;
    step(100);
    chk(mv() == m0, "R7 chattering minute key gives no step", mv(), m0);
    chk(hv() == h0, "R7 hours unchanged by chatter", hv(), h0);
  endtask

  // R5: minute key fast set, wrap without carry
  task automatic t_min_set();
    int h0, t59, t00, i;
    h0 = hv();
    key_sec = 1'b1;
    key_min = 1'b1;
    t59 = 0;
    t00 = 0;
    for (i = 0; i < 3000 && mv() != 59; i++) @(negedge clk);
    t59 = i;
    for (i = 0; i < 200 && mv() != 0; i++) @(negedge clk);
    t00 = i;
    chk(mv() == 0, "R5 minutes wrap 59 to 00", mv(), 0);
    chk(hv() == h0, "R5 key wrap leaves hours", hv(), h0);
    chk(t00 == FAST_CYC, "R5 one step per fast tick", t00, FAST_CYC);
    chk(t59 > 0, "R5 minutes reached 59", t59, 1);
    key_min = 1'b0;
    key_sec = 1'b0;
    step(100);
  endtask

  // R4: hour key fast set through 23 -> 00
  task automatic t_hour_set();
    int prev, bad, gap, last_t;
    bit wrapped;
    bad = 0;
    wrapped = 1'b0;
    gap = 0;
    last_t = -1;
    key_sec = 1'b1;
    key_hour = 1'b1;
    prev = hv();
    for (int i = 0; i < 1500 && !wrapped; i++) begin
      @(negedge clk);
      if (hv() != prev) begin
        if (hv() != (prev + 1) % 24 || hr_units > 9) bad++;
        if (last_t >= 0) gap = i - last_t;
        last_t = i;
        if (prev == 23 && hv() == 0) wrapped = 1'b1;
        prev = hv();
      end
    end
    chk(wrapped, "R4 hours wrap 23 to 00", hv(), 0);
    chk(bad == 0, "R4 hours step by one in BCD", bad, 0);
    chk(gap == FAST_CYC, "R4 one step per fast tick", gap, FAST_CYC);
    key_hour = 1'b0;
    step(100);
    key_sec = 1'b0;
  endtask

  task automatic set_minutes(input int target);
    int o, thr;
    key_sec = 1'b1;
    key_min = 1'b1;
    for (int i = 0; i < 3000 && mv() != 50; i++) @(negedge clk);
    key_min = 1'b0;
    step(150);
    o = (mv() - 50 + 60) % 60;
    thr = (target - o + 60) % 60;
    key_min = 1'b1;
    for (int i = 0; i < 3000 && mv() != thr; i++) @(negedge clk);
    key_min = 1'b0;
    step(150);
    chk(mv() == target, "R5 minutes set by key", mv(), target);
    key_sec = 1'b0;
  endtask

  // R9, R10, R11, R3: chime pattern and carry into hours
  task automatic t_chime();
    int c, h0;
    set_minutes(59);
    h0 = hv();
    for (int s = 50; s <= 59; s++) begin
      wait_sec(s, 14000);
      step(50);
      count_edges(100, c);
      if (s % 2 == 0) chk(c >= 45 && c <= 55, "R9 500 Hz on even second of 59:5x", c, 50);
      else            chk(c == 0, "R11 silent on odd second of 59:5x", c, 0);
    end
    wait_sec(0, 400);
    step(50);
    count_edges(100, c);
    chk(c >= 95, "R10 1 kHz at top of hour", c, 100);
    chk(mv() == 0, "R3 minutes carried to 00", mv(), 0);
    chk(hv() == (h0 + 1) % 24, "R3 hours advanced by carry", hv(), (h0 + 1) % 24);
  endtask

  // R8: minute-key step coinciding with seconds carry
  task automatic t_coincide();
    int ma, mb;
    key_min = 1'b1;
    step(100);
    wait_sec(59, 13000);
    step(10);
    ma = mv();
    wait_sec(0, 400);
    step(10);
    mb = mv();
    chk(mb == (ma + 10) % 60, "R8 merged carry and key step", mb, (ma + 10) % 60);
    key_min = 1'b0;
    step(100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_seconds();
    t_sec_clear();
    t_bounce();
    t_min_set();
    t_hour_set();
    t_chime();
    t_coincide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule